// File: doc/BRIEF.md
# Sequential Byte-Wide ROM Port with Auto-Increment

This block sits on the device side of a processor I/O bus and gives the processor byte-at-a-time access to a large read-only store that has no place in its memory map. The processor first issues a control command to the port. Bit 0 of that command byte decides whether later put-byte transfers may write to the store. It then sends two put-byte transfers that fill a 16-bit address counter: the high byte goes first, the low byte second. From then on, each get-byte transfer returns the byte at the counter and moves the counter on by one, so a long run of bytes is read with one get per byte.

On the store side, the port drives a synchronous address/data interface together with three active-low handshake lines. The first marks a new command (restart). The second marks the cycle in which the store is addressed (set). The third clears the array after the data has been taken (sample-and-reset). The byte is captured in the cycle between the set and reset phases, and an access always takes four cycles. Strobes that arrive during an access are dropped, so the processor must space its transfers at least four cycles apart.

Top module: `seq_rom_port`

## Requirements
- R1: The port acts only on strobes whose device address equals 1; a strobe carrying any other address changes no output and no internal state.
- R2: A control strobe copies command-byte bit 0 into the write-enable flag. It clears the high/low byte toggle and the address-loaded flag, and drives rom_restart_n low for exactly the one cycle after the strobe edge.
- R3: When the address is not yet loaded, the first put-byte after reset or after a control command loads rom_addr[15:8]. The second loads rom_addr[7:0] and marks the address as loaded. rom_addr shows each new value in the cycle after its strobe.
- R4: A get-byte with the address loaded reads the store at rom_addr. It raises io_rvalid for one cycle, the third cycle after the strobe edge, with the byte on io_rdata. rom_addr then increments by one in the following cycle.
- R5: The address counter wraps from 0xFFFF to 0x0000.
- R6: A get-byte that arrives before both address bytes are loaded returns 0xFF with the same io_rvalid timing. It leaves rom_addr unchanged and drives neither rom_rd, rom_wr, rom_set_n nor rom_sar_n.
- R7: A put-byte that arrives with the address loaded writes its byte to the store at rom_addr (rom_wr, with rom_wdata) when the write-enable flag is 1, then increments the counter. When the flag is 0, such a put-byte is ignored.
- R8: In every store access, rom_set_n is low for exactly the one cycle in which rom_rd or rom_wr is high. rom_sar_n is low for the single cycle two cycles later, which separates that access from the next.
- R9: Strobes that arrive while an access is in progress are ignored, and rom_addr holds steady through the access. When several strobes come in the same cycle, control wins over put, and put wins over get.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_dev | input | 4 | Device address of the current transfer |
| io_ctl | input | 1 | Control-command strobe, one cycle |
| io_put | input | 1 | Put-byte strobe, one cycle |
| io_get | input | 1 | Get-byte strobe, one cycle |
| io_wdata | input | 8 | Byte from the processor (command or put data) |
| io_rdata | output | 8 | Byte returned by a get |
| io_rvalid | output | 1 | io_rdata is valid this cycle |
| rom_addr | output | 16 | Address counter towards the store |
| rom_rd | output | 1 | Store read request |
| rom_wr | output | 1 | Store write request |
| rom_wdata | output | 8 | Byte to be written to the store |
| rom_rdata | input | 8 | Store data, valid the cycle after rom_rd |
| rom_restart_n | output | 1 | Active-low restart pulse after a command |
| rom_set_n | output | 1 | Active-low address phase of an access |
| rom_sar_n | output | 1 | Active-low sample-and-reset phase of an access |

## Verification
The bench targets the ordering of the two address bytes. It sends a single high byte and then a fresh command between the two bytes: a port that does not reset its toggle would put the next byte in the wrong half of the address. It drives reads and writes across the 0xFFFF boundary, where a counter that saturates or spills into a wider register would return the wrong next byte. It also reads before the address is complete, where a careless port would touch the store or move the counter. Finally, it sends extra strobes during an access and strobes that collide in one cycle: a port that re-arms too early would double-increment, and one with the wrong priority would return data when it should have restarted.

// File: rtl/seq_rom_pkg.sv
package seq_rom_pkg;

    localparam int RSP_BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ACC,
        PH_GATE,
        PH_SAR
    } phase_e;

    typedef enum logic [1:0] {
        K_READ,
        K_WRITE,
        K_MISS
    } kind_e;

    typedef struct packed {
        phase_e                 phase;
        kind_e                  kind;
        logic                   hi_done;
        logic                   loaded;
        logic                   wr_en;
        logic                   restart;
        logic                   rvalid;
        logic [RSP_BYTE_W-1:0]  rdata;
        logic [RSP_BYTE_W-1:0]  wdata;
    } seq_state_t;

endpackage

// File: rtl/rsp_cmd_decode.sv
module rsp_cmd_decode #(
    parameter int DEV_W  = 4,
    parameter int DEV_ID = 1
) (
    input  logic [DEV_W-1:0] io_dev,
    input  logic             io_ctl,
    input  logic             io_put,
    input  logic             io_get,
    input  logic             busy,
    output logic             ctl_go,
    output logic             put_go,
    output logic             get_go
);

    localparam logic [DEV_W-1:0] MY_DEV = DEV_W'(DEV_ID);

    logic hit;

    always_comb begin
        hit    = (io_dev == MY_DEV) && !busy;
        ctl_go = hit && io_ctl;
        put_go = hit && io_put && !io_ctl;
        get_go = hit && io_get && !io_ctl && !io_put;
    end

endmodule

// File: rtl/rsp_addr_ctr.sv
module rsp_addr_ctr #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_hi,
    input  logic                load_lo,
    input  logic                inc,
    input  logic [BYTE_W-1:0]   byte_in,
    output logic [2*BYTE_W-1:0] addr
);

    localparam int ADDR_W = 2 * BYTE_W;

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load_hi) begin
            addr_d[ADDR_W-1:BYTE_W] = byte_in;
        end else if (load_lo) begin
            addr_d[BYTE_W-1:0] = byte_in;
        end else if (inc) begin
            addr_d = addr_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/rsp_access_seq.sv
module rsp_access_seq
    import seq_rom_pkg::*;
#(
    parameter int BYTE_W = RSP_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_go,
    input  logic              put_go,
    input  logic              get_go,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [BYTE_W-1:0] rom_rdata,
    output logic              busy,
    output logic              load_hi,
    output logic              load_lo,
    output logic              inc,
    output logic [BYTE_W-1:0] io_rdata,
    output logic              io_rvalid,
    output logic              rom_rd,
    output logic              rom_wr,
    output logic [BYTE_W-1:0] rom_wdata,
    output logic              rom_restart_n,
    output logic              rom_set_n,
    output logic              rom_sar_n
);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.restart = 1'b0;
        st_d.rvalid  = 1'b0;
        load_hi      = 1'b0;
        load_lo      = 1'b0;
        inc          = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (ctl_go) begin
                    st_d.wr_en   = byte_in[0];
                    st_d.hi_done = 1'b0;
                    st_d.loaded  = 1'b0;
                    st_d.restart = 1'b1;
                end else if (put_go) begin
                    if (!st_q.loaded) begin
                        if (!st_q.hi_done) begin
                            load_hi      = 1'b1;
                            st_d.hi_done = 1'b1;
                        end else begin
                            load_lo     = 1'b1;
                            st_d.loaded = 1'b1;
                        end
                    end else if (st_q.wr_en) begin
                        st_d.phase = PH_ACC;
                        st_d.kind  = K_WRITE;
                        st_d.wdata = byte_in;
                    end
                end else if (get_go) begin
                    st_d.phase = PH_ACC;
                    st_d.kind  = st_q.loaded ? K_READ : K_MISS;
                end
            end
            PH_ACC: begin
                st_d.phase = PH_GATE;
            end
            PH_GATE: begin
                st_d.phase = PH_SAR;
                if (st_q.kind == K_READ) begin
                    st_d.rdata  = rom_rdata;
                    st_d.rvalid = 1'b1;
                end else if (st_q.kind == K_MISS) begin
                    st_d.rdata  = '1;
                    st_d.rvalid = 1'b1;
                end
            end
            PH_SAR: begin
                st_d.phase = PH_IDLE;
                inc        = (st_q.kind != K_MISS);
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, kind: K_READ, hi_done: 1'b0, loaded: 1'b0,
                      wr_en: 1'b0, restart: 1'b0, rvalid: 1'b0,
                      rdata: '0, wdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    logic touches_store;

    always_comb begin
        touches_store = (st_q.kind != K_MISS);
        busy          = (st_q.phase != PH_IDLE);
        rom_rd        = (st_q.phase == PH_ACC) && (st_q.kind == K_READ);
        rom_wr        = (st_q.phase == PH_ACC) && (st_q.kind == K_WRITE);
        rom_set_n     = !((st_q.phase == PH_ACC) && touches_store);
        rom_sar_n     = !((st_q.phase == PH_SAR) && touches_store);
        rom_restart_n = !st_q.restart;
        rom_wdata     = st_q.wdata;
        io_rdata      = st_q.rdata;
        io_rvalid     = st_q.rvalid;
    end

endmodule

// File: rtl/seq_rom_port.sv
module seq_rom_port
    import seq_rom_pkg::*;
#(
    parameter int BYTE_W = RSP_BYTE_W,
    parameter int DEV_W  = 4,
    parameter int DEV_ID = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DEV_W-1:0]    io_dev,
    input  logic                io_ctl,
    input  logic                io_put,
    input  logic                io_get,
    input  logic [BYTE_W-1:0]   io_wdata,
    output logic [BYTE_W-1:0]   io_rdata,
    output logic                io_rvalid,
    output logic [2*BYTE_W-1:0] rom_addr,
    output logic                rom_rd,
    output logic                rom_wr,
    output logic [BYTE_W-1:0]   rom_wdata,
    input  logic [BYTE_W-1:0]   rom_rdata,
    output logic                rom_restart_n,
    output logic                rom_set_n,
    output logic                rom_sar_n
);

    logic busy, ctl_go, put_go, get_go;
    logic load_hi, load_lo, inc;

    rsp_cmd_decode #(.DEV_W(DEV_W), .DEV_ID(DEV_ID)) u_dec (
        .io_dev (io_dev),
        .io_ctl (io_ctl),
        .io_put (io_put),
        .io_get (io_get),
        .busy   (busy),
        .ctl_go (ctl_go),
        .put_go (put_go),
        .get_go (get_go)
    );

    rsp_access_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_go        (ctl_go),
        .put_go        (put_go),
        .get_go        (get_go),
        .byte_in       (io_wdata),
        .rom_rdata     (rom_rdata),
        .busy          (busy),
        .load_hi       (load_hi),
        .load_lo       (load_lo),
        .inc           (inc),
        .io_rdata      (io_rdata),
        .io_rvalid     (io_rvalid),
        .rom_rd        (rom_rd),
        .rom_wr        (rom_wr),
        .rom_wdata     (rom_wdata),
        .rom_restart_n (rom_restart_n),
        .rom_set_n     (rom_set_n),
        .rom_sar_n     (rom_sar_n)
    );

    rsp_addr_ctr #(.BYTE_W(BYTE_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_hi (load_hi),
        .load_lo (load_lo),
        .inc     (inc),
        .byte_in (io_wdata),
        .addr    (rom_addr)
    );

endmodule

// File: rtl/seq_rom_port_chk.sv
module seq_rom_port_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [BYTE_W-1:0]   io_rdata,
    input logic                io_rvalid,
    input logic [2*BYTE_W-1:0] rom_addr,
    input logic                rom_rd,
    input logic                rom_wr,
    input logic                rom_restart_n,
    input logic                rom_set_n,
    input logic                rom_sar_n
);

    assert_set_marks_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_set_n |-> (rom_rd || rom_wr));

    assert_set_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_set_n |=> rom_set_n);

    assert_read_to_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |=> ##1 (io_rvalid && !rom_sar_n));

    assert_step_after_sar_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_sar_n |=> (rom_addr == $past(rom_addr) + 1'b1));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_sar_n && (rom_addr == '1)) |=> (rom_addr == '0));

    assert_miss_gives_ff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rvalid && rom_sar_n) |-> (io_rdata == '1));

    assert_addr_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_set_n |=> $stable(rom_addr));

    assert_restart_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_restart_n |-> (rom_set_n && rom_sar_n && !io_rvalid));

endmodule

bind seq_rom_port seq_rom_port_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_rdata      (io_rdata),
    .io_rvalid     (io_rvalid),
    .rom_addr      (rom_addr),
    .rom_rd        (rom_rd),
    .rom_wr        (rom_wr),
    .rom_restart_n (rom_restart_n),
    .rom_set_n     (rom_set_n),
    .rom_sar_n     (rom_sar_n)
);

// File: tb/tb_seq_rom_port.sv
`timescale 1ns/1ps
module tb_seq_rom_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_dev = '0;
    logic        io_ctl = 1'b0, io_put = 1'b0, io_get = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rvalid;
    logic [15:0] rom_addr;
    logic        rom_rd, rom_wr;
    logic [7:0]  rom_wdata;
    logic [7:0]  rom_rdata = '0;
    logic        rom_restart_n, rom_set_n, rom_sar_n;

    always #5 clk = ~clk;

    seq_rom_port dut (
        .clk(clk), .rst_n(rst_n), .io_dev(io_dev), .io_ctl(io_ctl), .io_put(io_put),
        .io_get(io_get), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
        .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_wr(rom_wr), .rom_wdata(rom_wdata),
        .rom_rdata(rom_rdata), .rom_restart_n(rom_restart_n), .rom_set_n(rom_set_n),
        .rom_sar_n(rom_sar_n)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;

    function automatic logic [7:0] rom_init(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    // Test store attached to the port
    logic [7:0] store_w [logic [15:0]];
    always @(posedge clk) begin
        if (rom_rd) rom_rdata <= store_w.exists(rom_addr) ? store_w[rom_addr] : rom_init(rom_addr);
        if (rom_wr) store_w[rom_addr] = rom_wdata;
    end

    // Behavioural reference model
    logic [7:0] ref_w [logic [15:0]];
    int         m_addr, m_left;
    bit         m_hi, m_loaded, m_we, m_miss, m_write;
    bit         e_rvalid, e_restart;
    logic [7:0] e_rdata;

    function automatic logic [7:0] ref_rd(input int a);
        logic [15:0] k = a[15:0];
        return ref_w.exists(k) ? ref_w[k] : rom_init(k);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_left = 0; m_hi = 0; m_loaded = 0; m_we = 0;
            m_miss = 0; m_write = 0; e_rvalid = 0; e_restart = 0; e_rdata = 8'h00;
        end else begin
            e_rvalid = 0; e_restart = 0;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 1 && !m_write) begin
                    e_rvalid = 1;
                    e_rdata = m_miss ? 8'hFF : ref_rd(m_addr);
                end
                if (m_left == 0 && !m_miss) m_addr = (m_addr + 1) % 65536;
            end else if (io_dev == 4'd1) begin
                if (io_ctl) begin
                    m_we = io_wdata[0]; m_hi = 0; m_loaded = 0; e_restart = 1;
                end else if (io_put) begin
                    if (!m_loaded) begin
                        if (!m_hi) begin m_addr = (m_addr % 256) + 256 * io_wdata; m_hi = 1; end
                        else begin m_addr = (m_addr / 256) * 256 + io_wdata; m_loaded = 1; end
                    end else if (m_we) begin
                        ref_w[m_addr[15:0]] = io_wdata;
                        m_left = 3; m_write = 1; m_miss = 0;
                    end
                end else if (io_get) begin
                    m_left = 3; m_write = 0; m_miss = !m_loaded;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge
    logic [7:0] got_q [$];
    always @(negedge clk) begin
        if (rst_n) begin
            bit ex_acc, ex_sar;
            ex_acc = (m_left == 3) && !m_miss;
            ex_sar = (m_left == 1) && !m_miss;
            check(rom_addr == m_addr[15:0], "R3", "rom_addr vs model", rom_addr, m_addr);
            check(io_rvalid == e_rvalid && (!e_rvalid || io_rdata == e_rdata), "R4",
                  "rvalid/rdata vs model", {io_rvalid, io_rdata}, {e_rvalid, e_rdata});
            check({rom_set_n, rom_sar_n, rom_restart_n, rom_rd, rom_wr} ==
                  {!ex_acc, !ex_sar, !e_restart, ex_acc && !m_write, ex_acc && m_write},
                  "R8", "handshake lines vs model",
                  {rom_set_n, rom_sar_n, rom_restart_n, rom_rd, rom_wr},
                  {!ex_acc, !ex_sar, !e_restart, ex_acc && !m_write, ex_acc && m_write});
            if (io_rvalid) got_q.push_back(io_rdata);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic xfer(input bit c, input bit p, input bit g, input logic [3:0] dv,
                        input logic [7:0] d);
        @(negedge clk);
        io_dev = dv; io_ctl = c; io_put = p; io_get = g; io_wdata = d;
        @(negedge clk);
        io_ctl = 0; io_put = 0; io_get = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] a, input bit we);
        xfer(1, 0, 0, 4'd1, {7'd0, we});
        xfer(0, 1, 0, 4'd1, a[15:8]);
        xfer(0, 1, 0, 4'd1, a[7:0]);
    endtask

    task automatic expect_byte(input string req, input logic [7:0] exp);
        logic [7:0] v = 8'h00;
        bit have = got_q.size() > 0;
        if (have) v = got_q.pop_front();
        check(have && v == exp, req, "returned byte", v, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!io_rvalid && rom_set_n && rom_sar_n && rom_restart_n && !rom_rd && !rom_wr,
              "R8", "reset idle lines", {io_rvalid, rom_set_n, rom_sar_n}, 3'b011);
        check(rom_addr == 16'h0000, "R3", "reset address", rom_addr, 0);

        // R6: read before any address load
        xfer(0, 0, 1, 4'd1, 8'h00);
        expect_byte("R6", 8'hFF);
        check(rom_addr == 16'h0000, "R6", "no step on miss", rom_addr, 0);

        // R1: other device addresses ignored
        xfer(1, 0, 0, 4'd2, 8'h01);
        xfer(0, 1, 0, 4'd3, 8'h77);
        xfer(0, 0, 1, 4'd0, 8'h00);
        check(got_q.size() == 0 && rom_addr == 16'h0000, "R1", "foreign device",
              rom_addr, 0);

        // R3, R4: load and read a run
        load(16'h1234, 0);
        check(rom_addr == 16'h1234, "R3", "address loaded high then low", rom_addr, 16'h1234);
        for (int i = 0; i < 3; i++) xfer(0, 0, 1, 4'd1, 8'h00);
        for (int i = 0; i < 3; i++) expect_byte("R4", rom_init(16'h1234 + 16'(i)));
        check(rom_addr == 16'h1237, "R4", "counter advanced", rom_addr, 16'h1237);

        // R7: put with write disabled ignored
        xfer(0, 1, 0, 4'd1, 8'hEE);
        check(rom_addr == 16'h1237, "R7", "put ignored without enable", rom_addr, 16'h1237);
        xfer(0, 0, 1, 4'd1, 8'h00);
        expect_byte("R7", rom_init(16'h1237));

        // R5, R7: write across the wrap
        load(16'hFFFF, 1);
        xfer(0, 1, 0, 4'd1, 8'hA5);
        check(rom_addr == 16'h0000, "R5", "write wrapped counter", rom_addr, 0);
        xfer(0, 1, 0, 4'd1, 8'h5A);
        load(16'hFFFF, 0);
        xfer(0, 0, 1, 4'd1, 8'h00);
        xfer(0, 0, 1, 4'd1, 8'h00);
        expect_byte("R7", 8'hA5);
        expect_byte("R5", 8'h5A);
        check(rom_addr == 16'h0001, "R5", "read wrap", rom_addr, 1);

        // R6: only the high byte loaded
        xfer(1, 0, 0, 4'd1, 8'h00);
        xfer(0, 1, 0, 4'd1, 8'h40);
        check(rom_addr == 16'h4001, "R3", "high byte only", rom_addr, 16'h4001);
        xfer(0, 0, 1, 4'd1, 8'h00);
        expect_byte("R6", 8'hFF);
        check(rom_addr == 16'h4001, "R6", "partial address unchanged", rom_addr, 16'h4001);

        // R2: fresh command restarts the byte toggle
        xfer(1, 0, 0, 4'd1, 8'h00);
        xfer(0, 1, 0, 4'd1, 8'h55);
        xfer(1, 0, 0, 4'd1, 8'h00);
        xfer(0, 1, 0, 4'd1, 8'h66);
        xfer(0, 1, 0, 4'd1, 8'h77);
        check(rom_addr == 16'h6677, "R2", "toggle reset by command", rom_addr, 16'h6677);

        // R9: second get during an access is ignored
        @(negedge clk);
        io_dev = 4'd1; io_get = 1;
        repeat (2) @(negedge clk);
        io_get = 0;
        repeat (5) @(negedge clk);
        check(got_q.size() == 1 && rom_addr == 16'h6678, "R9", "busy strobe dropped",
              rom_addr, 16'h6678);
        expect_byte("R9", rom_init(16'h6677));

        // R9: control beats get in the same cycle
        @(negedge clk);
        io_dev = 4'd1; io_ctl = 1; io_get = 1; io_wdata = 8'h00;
        @(negedge clk);
        check(!rom_restart_n, "R9", "control wins collision", rom_restart_n, 0);
        io_ctl = 0; io_get = 0;
        repeat (5) @(negedge clk);
        check(got_q.size() == 0, "R9", "no get after collision", got_q.size(), 0);

        // R9: put beats get in the same cycle (loads high byte)
        @(negedge clk);
        io_dev = 4'd1; io_put = 1; io_get = 1; io_wdata = 8'h21;
        @(negedge clk);
        io_put = 0; io_get = 0;
        repeat (5) @(negedge clk);
        check(got_q.size() == 0 && rom_addr == 16'h2178, "R9", "put wins collision",
              rom_addr, 16'h2178);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule